// File: doc/BRIEF.md
# Multiplexed-Address Reduced-Latency DRAM Initialisation Sequencer

This block sits on the controller side of a reduced-latency DRAM link. It runs the device's start-up sequence while the device is in multiplexed address mode. When synchronous reset is released, the sequencer holds the command bus at NOP for the stabilisation time, which is counted in clock cycles from the clock frequency parameter. It then issues a fixed number of mode-register writes. Each write carries its address in two halves on consecutive cycles: the first half (X) goes out with the MRS command and the second half (Y) follows under a NOP. After the writes, the sequencer refreshes banks 0 to 7 one at a time. It then waits out the DLL-lock and settling window and raises `init_done`. No other command may be issued before `init_done`.

The mode-register settings come from static inputs: configuration, burst length, termination, impedance and DLL reset. These inputs are captured while reset is held. A burst length that the chosen configuration cannot use is replaced by the default, and the `cfg_err` flag is raised.

The states are ST_STAB, ST_MRS_X, ST_MRS_Y, ST_MRS_GAP, ST_REF, ST_REF_GAP, ST_FINAL and ST_DONE. They are entered in this order:

- ST_STAB → ST_MRS_X when the timer expires.
- ST_MRS_X → ST_MRS_Y on the next cycle.
- ST_MRS_Y → ST_MRS_GAP on the next cycle, reloading the timer.
- ST_MRS_GAP → ST_MRS_X on expiry if writes remain, otherwise ST_MRS_GAP → ST_REF.
- ST_REF → ST_REF_GAP on the next cycle, reloading the timer.
- ST_REF_GAP → ST_REF on expiry if banks remain, otherwise ST_REF_GAP → ST_FINAL.
- ST_FINAL → ST_DONE on expiry.

ST_DONE holds until reset.

Top module: `rlm_mux_init_seq`

## Requirements
- R1: While `rst` is high, and for exactly STAB = CLK_MHZ×PWRUP_US cycles after it falls, `cmd` is NOP (2'b00), `bank` and `addr` are zero and `init_done` is low.
- R2: Every MRS (cmd 2'b01) cycle is followed directly by a cycle with cmd NOP that carries the Y half on `addr`.
- R3: In both halves of every mode-register write, `addr[5]` is 1, `addr[17:10]` is 0 and every bit not named in R7 is 0. Outside those two cycles, `addr` is 0.
- R4: N_MRS writes are issued with their MRS cycles exactly MRSC = max(T_MRSC,3) cycles apart. The first REFRESH comes MRSC cycles after the last MRS. All cycles in between are NOP.
- R5: REFRESH (cmd 2'b10) is issued once to each bank 0..7 in ascending order, exactly RC = max(T_RC,2) cycles apart, with `bank` holding the target bank. Every cycle between refreshes is NOP.
- R6: `init_done` rises exactly RC + FINAL_MULT×DLL_LOCK cycles after the last REFRESH, and `cmd` is NOP until then.
- R7: The X half encodes the settings as follows:
  - bit0 = configuration bit 0
  - bits 4:3 = burst code (00 = 2, 01 = 4, 10 = 8, 11 reserved)
  - bit8 = external impedance
  - bit9 = DLL reset

  The Y half encodes:
  - bits 4:3 = configuration bits 2:1
  - bit9 = on-die termination enable
- R8: `cfg_err` is high when the burst code is 11, or when it is 10 with configuration 1. In those cases the X half carries burst code 01 in place of the requested code.
- R9: Once `init_done` is high it stays high until reset, with `cmd` NOP, and `bank` and `addr` zero.
- R10: Settings are captured while `rst` is high. Changes to `cfg_sel`, `bl_sel`, `odt_en`, `ext_imp` and `dll_rst` after release do not affect the emitted halves.
- R11: Asserting `rst` in the middle of the sequence returns the block to the R1 state and restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; settings are captured while high |
| cfg_sel | input | 3 | Configuration number (1..3) |
| bl_sel | input | 2 | Burst code: 00 = 2, 01 = 4, 10 = 8, 11 reserved |
| odt_en | input | 1 | On-die termination enable |
| ext_imp | input | 1 | 1 = external impedance resistor, 0 = internal |
| dll_rst | input | 1 | DLL reset bit for the mode register |
| cmd | output | 2 | Command: 00 NOP, 01 MRS, 10 REFRESH |
| bank | output | 3 | Refresh target bank |
| addr | output | 18 | Multiplexed address bus |
| init_done | output | 1 | Initialisation complete, sticky until reset |
| cfg_err | output | 1 | Burst length rejected and replaced by the default |

## Verification
The hardest situation to reach is the end of the sequence. `init_done` only rises after more than 37,000 cycles of mostly NOP output, and the refresh spacing and final window can only be seen by running the whole sequence. The bench therefore runs one complete sequence, comparing against a cycle-indexed reference model on every clock. It then resets in the middle of the mode-register phase to reach the restart case. Further runs with rejected burst settings and with inputs toggled after release cover the substitution and capture behaviour.

// File: rtl/rlm_init_pkg.sv
package rlm_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_MRS = 2'b01,
        CMD_REF = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        ST_STAB,
        ST_MRS_X,
        ST_MRS_Y,
        ST_MRS_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_FINAL,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [2:0] sel;
        logic [1:0] bl;
        logic       odt;
        logic       ext_imp;
        logic       dll_rst;
    } mode_cfg_t;

    localparam logic [1:0] BL_CODE_8   = 2'b10;
    localparam logic [1:0] BL_CODE_RSV = 2'b11;
    localparam logic [1:0] BL_DEFAULT  = 2'b01;

endpackage

// File: rtl/rlm_wait_timer.sv
module rlm_wait_timer #(
    parameter int          CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4/R5/R6 spacing depends on a steady one-per-cycle count
    p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rlm_mode_encoder.sv
module rlm_mode_encoder
    import rlm_init_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  mode_cfg_t          cfg,
    input  logic               half_y,
    output logic [ADDR_W-1:0]  word,
    output logic               bl_reject
);

    logic [1:0] bl_use;

    always_comb begin
        bl_reject = (cfg.bl == BL_CODE_RSV) ||
                    (cfg.bl == BL_CODE_8 && cfg.sel == 3'd1);
        bl_use    = bl_reject ? BL_DEFAULT : cfg.bl;
        word      = '0;
        word[5]   = 1'b1;
        if (!half_y) begin
            word[0] = cfg.sel[0];
            word[3] = bl_use[0];
            word[4] = bl_use[1];
            word[8] = cfg.ext_imp;
            word[9] = cfg.dll_rst;
        end else begin
            word[3] = cfg.sel[1];
            word[4] = cfg.sel[2];
            word[9] = cfg.odt;
        end
    end

endmodule

// File: rtl/rlm_mux_init_seq.sv
module rlm_mux_init_seq
    import rlm_init_pkg::*;
#(
    parameter int CLK_MHZ    = 125,
    parameter int PWRUP_US   = 200,
    parameter int T_MRSC     = 6,
    parameter int T_RC       = 8,
    parameter int N_MRS      = 3,
    parameter int NUM_BANKS  = 8,
    parameter int DLL_LOCK   = 2048,
    parameter int FINAL_MULT = 6,
    parameter int ADDR_W     = 18,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_sel,
    input  logic [1:0]        bl_sel,
    input  logic              odt_en,
    input  logic              ext_imp,
    input  logic              dll_rst,
    output logic [1:0]        cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              cfg_err
);

    localparam int STAB_CYC  = CLK_MHZ * PWRUP_US;
    localparam int MRSC_EFF  = (T_MRSC < 3) ? 3 : T_MRSC;
    localparam int RC_EFF    = (T_RC < 2) ? 2 : T_RC;
    localparam int FINAL_CYC = FINAL_MULT * DLL_LOCK;
    localparam int MAX_A     = (STAB_CYC > FINAL_CYC) ? STAB_CYC : FINAL_CYC;
    localparam int MAX_B     = (MRSC_EFF > RC_EFF) ? MRSC_EFF : RC_EFF;
    localparam int MAX_WAIT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);
    localparam int MRS_W     = (N_MRS > 1) ? $clog2(N_MRS) : 1;

    state_e             state_q, state_d;
    logic [MRS_W-1:0]   mrs_idx_q;
    logic [BANK_W-1:0]  bank_q;
    mode_cfg_t          cfg_q;
    logic               tmr_load, tmr_exp;
    logic [CNT_W-1:0]   tmr_val;
    logic [ADDR_W-1:0]  mode_word;
    logic               last_mrs, last_bank;
    cmd_e               cmd_int;

    // settings captured while reset is held (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.sel     <= cfg_sel;
            cfg_q.bl      <= bl_sel;
            cfg_q.odt     <= odt_en;
            cfg_q.ext_imp <= ext_imp;
            cfg_q.dll_rst <= dll_rst;
        end
    end

    rlm_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STAB_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    rlm_mode_encoder #(
        .ADDR_W (ADDR_W)
    ) u_enc (
        .cfg       (cfg_q),
        .half_y    (state_q == ST_MRS_Y),
        .word      (mode_word),
        .bl_reject (cfg_err)
    );

    assign last_mrs  = (mrs_idx_q == MRS_W'(N_MRS - 1));
    assign last_bank = (bank_q == BANK_W'(NUM_BANKS - 1));

    // state register and sequence indices
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_STAB;
            mrs_idx_q <= '0;
            bank_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_MRS_GAP && tmr_exp && !last_mrs)
                mrs_idx_q <= mrs_idx_q + 1'b1;
            if (state_q == ST_REF_GAP && tmr_exp && !last_bank)
                bank_q <= bank_q + 1'b1;
        end
    end

    // transitions and timer reloads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_STAB:    if (tmr_exp) state_d = ST_MRS_X;
            ST_MRS_X:   state_d = ST_MRS_Y;
            ST_MRS_Y: begin
                state_d  = ST_MRS_GAP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(MRSC_EFF - 3);
            end
            ST_MRS_GAP: if (tmr_exp) state_d = last_mrs ? ST_REF : ST_MRS_X;
            ST_REF: begin
                state_d  = ST_REF_GAP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RC_EFF - 2);
            end
            ST_REF_GAP: begin
                if (tmr_exp) begin
                    if (last_bank) begin
                        state_d  = ST_FINAL;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(FINAL_CYC - 1);
                    end else begin
                        state_d = ST_REF;
                    end
                end
            end
            ST_FINAL:   if (tmr_exp) state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_STAB;
        endcase
    end

    // outputs
    always_comb begin
        cmd_int   = CMD_NOP;
        bank      = '0;
        addr      = '0;
        init_done = 1'b0;
        unique case (state_q)
            ST_MRS_X: begin
                cmd_int = CMD_MRS;
                addr    = mode_word;
            end
            ST_MRS_Y: addr = mode_word;
            ST_REF: begin
                cmd_int = CMD_REF;
                bank    = bank_q;
            end
            ST_DONE:  init_done = 1'b1;
            default:  ;
        endcase
    end

    assign cmd = cmd_int;

    p_mrs_fixed_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_int == CMD_MRS) |-> (addr[5] && addr[17:10] == '0));

    p_y_half_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_int == CMD_MRS) |=> (cmd_int == CMD_NOP && addr[5]));

    p_bl_substitute_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_int == CMD_MRS && cfg_err) |-> (addr[4:3] == BL_DEFAULT));

    p_ref_spaced_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_int == CMD_REF) |=> (cmd_int == CMD_NOP));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && cmd_int == CMD_NOP));

endmodule

// File: tb/rlm_mux_init_seq_test.sv
module rlm_mux_init_seq_test;

    localparam int CLK_MHZ    = 125;
    localparam int PWRUP_US   = 200;
    localparam int T_MRSC     = 6;
    localparam int T_RC       = 8;
    localparam int N_MRS      = 3;
    localparam int NUM_BANKS  = 8;
    localparam int DLL_LOCK   = 2048;
    localparam int FINAL_MULT = 6;
    localparam int STAB       = CLK_MHZ * PWRUP_US;
    localparam int FINAL      = FINAL_MULT * DLL_LOCK;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_sel = 3'd2;
    logic [1:0]  bl_sel = 2'b00;
    logic        odt_en = 1'b0, ext_imp = 1'b0, dll_rst = 1'b0;
    logic [1:0]  cmd;
    logic [2:0]  bank;
    logic [17:0] addr;
    logic        init_done, cfg_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rlm_mux_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_MRSC(T_MRSC), .T_RC(T_RC),
        .N_MRS(N_MRS), .NUM_BANKS(NUM_BANKS), .DLL_LOCK(DLL_LOCK),
        .FINAL_MULT(FINAL_MULT), .ADDR_W(18)
    ) uut (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .bl_sel(bl_sel),
        .odt_en(odt_en), .ext_imp(ext_imp), .dll_rst(dll_rst),
        .cmd(cmd), .bank(bank), .addr(addr),
        .init_done(init_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [17:0] half_word(input bit y, input logic [2:0] c,
            input logic [1:0] b, input bit odt, input bit ext, input bit dll);
        logic [17:0] w;
        logic [1:0]  bu;
        bu = ((b == 2'b11) || (b == 2'b10 && c == 3'd1)) ? 2'b01 : b;
        w = '0;
        w[5] = 1'b1;
        if (!y) begin
            w[0] = c[0]; w[4:3] = bu; w[8] = ext; w[9] = dll;
        end else begin
            w[4:3] = c[2:1]; w[9] = odt;
        end
        return w;
    endfunction

    // expected {cmd, bank, addr, done} for cycle k after reset release
    task automatic model(input int k, input logic [2:0] c, input logic [1:0] b,
                         input bit odt, input bit ext, input bit dll,
                         output logic [23:0] ev, output string tag);
        int m, r, f;
        ev  = '0;
        tag = "R1";
        m = k - STAB;
        if (k < STAB) begin
            tag = "R1";
        end else if (m < N_MRS * T_MRSC) begin
            if (m % T_MRSC == 0) begin
                ev  = {2'b01, 3'd0, half_word(0, c, b, odt, ext, dll), 1'b0};
                tag = "R7";
            end else if (m % T_MRSC == 1) begin
                ev  = {2'b00, 3'd0, half_word(1, c, b, odt, ext, dll), 1'b0};
                tag = "R2";
            end else begin
                tag = "R4";
            end
        end else begin
            r = m - N_MRS * T_MRSC;
            if (r < NUM_BANKS * T_RC) begin
                tag = "R5";
                if (r % T_RC == 0)
                    ev = {2'b10, 3'(r / T_RC), 18'd0, 1'b0};
            end else begin
                f = r - NUM_BANKS * T_RC;
                if (f < FINAL) begin
                    tag = "R6";
                end else begin
                    ev  = {2'b00, 3'd0, 18'd0, 1'b1};
                    tag = (f == FINAL) ? "R6" : "R9";
                end
            end
        end
    endtask

    task automatic run(input logic [2:0] c, input logic [1:0] b, input bit odt,
                       input bit ext, input bit dll, input int ncyc,
                       input bit flip, input string rst_tag);
        logic [23:0] ev;
        string       tag;
        bit          exp_err;
        int          base;
        @(negedge clk);
        rst = 1'b1;
        cfg_sel = c; bl_sel = b; odt_en = odt; ext_imp = ext; dll_rst = dll;
        repeat (3) @(negedge clk);
        chk(cmd == 2'b00 && init_done == 1'b0 && addr == '0, rst_tag,
            "outputs during reset", {cmd, init_done}, 0);
        exp_err = (b == 2'b11) || (b == 2'b10 && c == 3'd1);
        rst  = 1'b0;
        base = fails;
        for (int k = 0; k < ncyc; k++) begin
            model(k, c, b, odt, ext, dll, ev, tag);
            if (flip && ev[23:22] == 2'b01) tag = "R10";
            if (k == 0 && rst_tag == "R11") tag = "R11";
            chk({cmd, bank, addr, init_done} == ev, tag,
                $sformatf("cycle %0d {cmd,bank,addr,done}", k),
                32'({cmd, bank, addr, init_done}), 32'(ev));
            if (ev[23:22] == 2'b01)
                chk(addr[5] == 1'b1 && addr[17:10] == '0, "R3",
                    "fixed MRS bits", 32'(addr), 32'(ev[18:1]));
            chk(cfg_err == exp_err, "R8", "cfg_err", 32'(cfg_err), 32'(exp_err));
            if (flip && k == 2) begin
                cfg_sel = ~c; bl_sel = ~b; odt_en = ~odt;
                ext_imp = ~ext; dll_rst = ~dll;
            end
            if (fails - base > 5) break;
            @(negedge clk);
        end
    endtask

    initial begin
        // full sequence, configuration 2 with burst 8 (legal)
        run(3'd2, 2'b10, 1'b1, 1'b0, 1'b1,
            STAB + N_MRS * T_MRSC + NUM_BANKS * T_RC + FINAL + 40, 1'b0, "R1");
        // configuration 1 with burst 8: rejected; inputs toggled after release;
        // aborted partway through the mode-register phase
        run(3'd1, 2'b10, 1'b0, 1'b1, 1'b0, STAB + 10, 1'b1, "R1");
        // restart after abort, reserved burst code
        run(3'd3, 2'b11, 1'b1, 1'b1, 1'b0,
            STAB + N_MRS * T_MRSC + 2 * T_RC + 2, 1'b0, "R11");
        // configuration 1 with burst 4: accepted
        run(3'd1, 2'b01, 1'b0, 1'b0, 1'b1, STAB + N_MRS * T_MRSC + 4, 1'b0, "R1");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule